// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps the elapsed time since reset in a 67-bit fixed-point accumulator. The low 16 bits hold fractions of a microsecond and the upper bits hold whole microseconds. On every slow-clock tick the accumulator adds a programmable step. The step gives the tick period in microseconds as a Q.16 value, so a 32.768 kHz source uses a step of 2,000,000, which is about 30.5176 µs. Because of this, the count is always in real time units, whatever tick rate is used.

Software sees the time through two 32-bit windows of the accumulator. The fine window has an 8 µs LSB and wraps after roughly 9.5 hours. The coarse window has a 524.288 ms LSB and spans about 71 years. Reading the fine window also freezes a copy of the coarse window, so a pair read fine-first is always consistent.

One compare channel, matched against the fine window, produces a single-cycle wake event. One capture channel records the fine window when an external trigger is seen. The slow tick arrives as a one-cycle strobe in the block's clock domain. A synchronous clear input stands for a device reset or shutdown indication.

Top module: `rtc_frac_counter`

## Requirements
- R1: After reset the step register reads 2,000,000 (0x001E8480). The fine window, the coarse copy, the compare value, the capture value and the status word all read 0, and `wake_evt` is low.
- R2: On each clock with `lf_tick` high and `off_clr` low, the accumulator becomes (accumulator + step) mod 2^67. With `lf_tick` low it holds its value.
- R3: Address 1 returns the fine window, accumulator bits [50:19], combinationally.
- R4: A read of address 1 copies accumulator bits [66:35] into a holding register. Address 2 returns that held copy, not the live bits.
- R5: `off_clr` high on a clock edge sets the accumulator to zero. It leaves the step, compare and capture registers unchanged.
- R6: A write to address 3 loads the compare value and arms the channel. At each clock edge where the channel is armed and (fine − compare) mod 2^32 < 2^31, the channel disarms and `wake_evt` is high for exactly the following clock cycle. This covers both equality and values already passed. It fires once per write.
- R7: A rising edge on `cap_in` marks a capture as pending. At the next tick, the fine window value from before that tick's addition is stored at address 4, and the capture flag is set.
- R8: Address 5 returns the status word: bit 0 is the capture flag and bit 1 is the compare-armed state. A read of address 5 clears the capture flag, unless a capture sets it on the same edge.
- R9: Only address 0 (step) and address 3 (compare) are writable. Writes to addresses 1, 2, 4 and 5 change nothing that can be read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_clr | input | 1 | Synchronous accumulator clear (reset/shutdown indication) |
| lf_tick | input | 1 | One-cycle slow-clock tick strobe |
| cap_in | input | 1 | Capture trigger, rising edge sensitive |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (applies read side effects) |
| addr | input | 3 | Register address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| wake_evt | output | 1 | One-cycle compare event |

## Verification
The compare rule is tested in three situations: a value that is already in the past, a value reached exactly with a one-LSB-per-tick step, and a value reached by overshoot. A design that tests only equality would miss the overshoot. A design that does not disarm would pulse on every later cycle. The coarse copy is read several ticks after its fine read; a design that returns live bits gives a different number. The capture value is checked against the fine window from before the tick's addition, and the clear-on-read flag is read twice. Random step sizes up to the full 32 bits exercise carries into the upper accumulator bits, which a narrower adder would drop.

// File: rtl/rtc_frac_counter.sv
module rtc_frac_counter #(
  parameter int          ACC_W     = 67,
  parameter int          FINE_LO   = 19,
  parameter int          COARSE_LO = 35,
  parameter logic [31:0] STEP_RST  = 32'd2000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        off_clr,
  input  logic        lf_tick,
  input  logic        cap_in,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [2:0]  addr,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        wake_evt
);
  localparam int FINE_HI   = FINE_LO + 31;
  localparam int COARSE_HI = COARSE_LO + 31;
  localparam logic [2:0] A_STEP = 3'd0, A_FINE = 3'd1, A_COARSE = 3'd2,
                         A_CMP = 3'd3, A_CAP = 3'd4, A_STAT = 3'd5;

  logic [ACC_W-1:0] acc;
  logic [31:0] step, cmp_val, cap_val, hold;
  logic armed, cap_flag, cap_pend, cap_q, evt_q;

  wire [31:0] fine   = acc[FINE_HI:FINE_LO];
  wire [31:0] coarse = acc[COARSE_HI:COARSE_LO];
  wire [31:0] gap    = fine - cmp_val;
  wire        passed = ~gap[31];
  wire        wr_step = wr_en && addr == A_STEP;
  wire        wr_cmp  = wr_en && addr == A_CMP;
  wire        rd_fine = rd_en && addr == A_FINE;
  wire        rd_stat = rd_en && addr == A_STAT;
  wire        cap_go  = lf_tick && cap_pend;

  assign wake_evt = evt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       acc <= '0;
    else if (off_clr) acc <= '0;
    else if (lf_tick) acc <= acc + ACC_W'(step);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      step <= STEP_RST; hold <= '0;
    end else begin
      if (wr_step) step <= wr_data;
      if (rd_fine) hold <= coarse;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_val <= '0; armed <= 1'b0; evt_q <= 1'b0;
    end else begin
      evt_q <= armed && passed;
      if (wr_cmp) begin
        cmp_val <= wr_data; armed <= 1'b1;
      end else if (armed && passed) armed <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_q <= 1'b0; cap_pend <= 1'b0; cap_flag <= 1'b0; cap_val <= '0;
    end else begin
      cap_q <= cap_in;
      if (rd_stat) cap_flag <= 1'b0;
      if (cap_go) begin
        cap_val <= fine; cap_flag <= 1'b1; cap_pend <= 1'b0;
      end
      if (cap_in && !cap_q) cap_pend <= 1'b1;
    end

  always_comb
    case (addr)
      A_STEP:   rd_data = step;
      A_FINE:   rd_data = fine;
      A_COARSE: rd_data = hold;
      A_CMP:    rd_data = cmp_val;
      A_CAP:    rd_data = cap_val;
      A_STAT:   rd_data = {30'd0, armed, cap_flag};
      default:  rd_data = '0;
    endcase

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lf_tick && !off_clr |=> $stable(acc));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lf_tick && !off_clr |=> acc == $past(acc) + ACC_W'($past(step)));
  p_snap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fine |=> hold == $past(coarse));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off_clr |=> acc == '0);
  p_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt && !wr_cmp |=> !wake_evt);
  p_disarm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_evt) |-> !armed || $past(wr_cmp));
  p_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_go |=> cap_flag && cap_val == $past(fine));
endmodule

// File: tb/rtc_frac_counter_test.sv
module rtc_frac_counter_test;
  logic clk = 0, rst_n = 0, off_clr = 0, lf_tick = 0, cap_in = 0;
  logic wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic wake_evt;
  int total = 0, bad = 0;

  logic [66:0] m_acc;
  logic [31:0] m_step, m_cmp, m_cap, m_hold;
  logic m_armed, m_flag, m_pend;

  rtc_frac_counter uut (.clk(clk), .rst_n(rst_n), .off_clr(off_clr), .lf_tick(lf_tick),
    .cap_in(cap_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .wake_evt(wake_evt));

  always #5 clk = ~clk;

  function automatic logic [31:0] fine_of(logic [66:0] a); return a[50:19]; endfunction
  function automatic logic [31:0] coarse_of(logic [66:0] a); return a[66:35]; endfunction
  function automatic logic hit(logic [31:0] f, logic [31:0] c);
    logic [31:0] d = f - c; return ~d[31];
  endfunction
  function automatic logic [31:0] exp_reg(logic [2:0] a);
    case (a)
      3'd0: return m_step;
      3'd1: return fine_of(m_acc);
      3'd2: return m_hold;
      3'd3: return m_cmp;
      3'd4: return m_cap;
      3'd5: return {30'd0, m_armed, m_flag};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic settle();
    logic e;
    @(negedge clk);
    e = m_armed && hit(fine_of(m_acc), m_cmp);
    if (e) m_armed = 0;
    check("R6 wake_evt", {31'd0, wake_evt}, {31'd0, e});
  endtask

  task automatic do_tick();
    lf_tick = 1; @(negedge clk); lf_tick = 0;
    if (m_pend) begin m_cap = fine_of(m_acc); m_flag = 1; m_pend = 0; end
    m_acc = m_acc + {35'd0, m_step};
    settle();
  endtask

  task automatic do_write(logic [2:0] a, logic [31:0] d);
    wr_en = 1; addr = a; wr_data = d; @(negedge clk); wr_en = 0;
    if (a == 3'd0) m_step = d;
    if (a == 3'd3) begin m_cmp = d; m_armed = 1; end
    settle();
  endtask

  task automatic do_read(logic [2:0] a, string tag);
    rd_en = 1; addr = a; #1;
    check(tag, rd_data, exp_reg(a));
    @(negedge clk); rd_en = 0;
    if (a == 3'd1) m_hold = coarse_of(m_acc);
    if (a == 3'd5) m_flag = 0;
    settle();
  endtask

  task automatic do_cap(logic v);
    if (v && !cap_in) m_pend = 1;
    cap_in = v; @(negedge clk); settle();
  endtask

  task automatic do_clr();
    off_clr = 1; @(negedge clk); off_clr = 0; m_acc = '0; settle();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    int s;
    s = $urandom(32'd1234);
    m_acc = '0; m_step = 32'd2000000; m_cmp = 0; m_cap = 0; m_hold = 0;
    m_armed = 0; m_flag = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    check("R1 wake_evt", {31'd0, wake_evt}, 32'd0);
    rst_n = 1; @(negedge clk);
    for (int a = 0; a < 6; a++) do_read(3'(a), "R1 reset read");

    repeat (4) do_tick();
    do_read(3'd1, "R3 fine after default ticks");
    check("R2 fine 8e6>>19", fine_of(m_acc), 32'd15);

    do_write(3'd0, 32'hFFFF_FFFF);
    repeat (20) do_tick();
    do_read(3'd1, "R3 fine big step");
    repeat (3) do_tick();
    do_read(3'd2, "R4 coarse held copy");

    do_write(3'd1, 32'hDEAD_BEEF);
    do_write(3'd4, 32'h1234_5678);
    do_read(3'd1, "R9 fine unchanged");
    do_read(3'd4, "R9 capture unchanged");

    do_write(3'd3, fine_of(m_acc) - 32'd5);
    do_read(3'd5, "R6 disarmed after past compare");
    do_write(3'd3, fine_of(m_acc) + 32'd20000);
    repeat (4) do_tick();
    do_read(3'd5, "R6 disarmed after overshoot");

    do_write(3'd0, 32'h0008_0000);
    do_write(3'd3, fine_of(m_acc) + 32'd2);
    repeat (3) do_tick();
    do_read(3'd3, "R6 compare value");

    do_cap(1'b1);
    do_read(3'd5, "R7 no flag before tick");
    do_tick();
    do_cap(1'b0);
    do_read(3'd4, "R7 captured fine");
    do_read(3'd5, "R8 flag set");
    do_read(3'd5, "R8 flag cleared by read");

    do_clr();
    do_read(3'd1, "R5 fine cleared");
    do_read(3'd0, "R5 step kept");
    do_read(3'd4, "R5 capture kept");

    for (int i = 0; i < 400; i++) begin
      case ($urandom % 8)
        0, 1: do_tick();
        2: do_write(3'd0, ($urandom % 2) ? $urandom : ($urandom % 32'h0100_0000));
        3: do_read(3'd1, "R3 random fine");
        4: do_read(3'd2, "R4 random coarse");
        5: do_write(3'd3, fine_of(m_acc) + ($urandom % 4000) - 32'd1000);
        6: do_cap(~cap_in);
        default: do_read(3'(4 + $urandom % 2), "R8 random cap/status");
      endcase
    end
    summary();
  end
endmodule